// File: doc/BRIEF.md
# Configurable 16-bit Peripheral Timer

This block is a 16-bit up-counter behind a byte-wide synchronous register bus. Software picks where count pulses come from: the system clock, the system clock divided by four, or an external pin or secondary oscillator input. Software also sets a power-of-two prescale ratio and whether the external input is synchronised first. A run bit starts and stops counting. When the count wraps from all ones to zero, a sticky overflow flag is set. Software clears the flag by writing zero to it.

The count can be accessed as two independent bytes, or in a buffered wide mode. In wide mode a low-byte read takes a snapshot of the high byte, and a high-byte write is held until the low byte is written. A typical use is elapsed-time measurement: clear the count, set run, stop it later, then read both bytes and the flag.

Top module: `periph_timer16`

## Requirements
- R1: After reset, all four registers read 0x00 and `ovf_o` is low. Address map: 0 is control, 1 is count low byte, 2 is count high byte, 3 is status. Status bit 0 is the overflow flag and its other bits read 0.
- R2: Control bits 7:6 pick the count source. Value 01 gives one pulse per system clock. Value 00 gives one pulse every fourth clock, from a divider that runs freely from reset.
- R3: Control bits 5:4 = n make the count advance once per 2^n source pulses (n = 0 to 3).
- R4: With source 10, control bit 3 picks the oscillator input (1) or the pin (0). Control bit 2 = 0 synchronises the input, so a rising edge seen at clock k advances the prescaler at clock k+2. Control bit 2 = 1 uses the input unsynchronised, so the edge advances it at clock k. Bits 3 and 2 have no effect for the internal sources.
- R5: Source 11 never advances the count.
- R6: While control bit 0 is 0, the count holds its value. Writing bit 0 = 0 also discards partial prescale progress.
- R7: The flag sets when an increment wraps 0xFFFF to 0x0000, and it stays set. Writing status bit 0 = 0 clears it, and writing 1 has no effect. If a wrap and a clear happen in the same cycle, the set wins.
- R8: With control bit 1 = 0, each count byte is read and written directly and on its own.
- R9: With control bit 1 = 1, a read of the low byte latches the high byte, and later high-byte reads return that latch. A high-byte write fills a buffer that is loaded into the count together with the next low-byte write.
- R10: The prescaler restarts from zero on any count-byte write, on a control write that changes bits 5:4, and on a control write with bit 0 = 0.
- R11: A write to the count itself takes precedence over an increment in the same cycle, and that increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (drives the wide-mode snapshot) |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| pin_i | input | 1 | External count pin |
| osc_i | input | 1 | Secondary oscillator input |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench goes after several timing corner cases:
- Pin edges on both synchronised paths, with the pin and oscillator toggling at the same time. A wrong latency or a wrong input select shifts every count taken afterwards.
- Clears written to the flag in the same cycles as a wrap. A design with the wrong priority loses the overflow.
- Prescale changes and count writes in the middle of a prescale period. A design that keeps the stale prescaler residue counts early.
- A wide-mode snapshot followed by further counting. Returning the live high byte shows up as a mismatch against the latched value.
- Source 11 and the halted state. Any stray increment in either is caught.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    SRC_DIV4 = 2'b00,
    SRC_SYS  = 2'b01,
    SRC_EXT  = 2'b10,
    SRC_RSVD = 2'b11
  } src_e;

  typedef struct packed {
    src_e       src;
    logic [1:0] ps;
    logic       osc_sel;
    logic       nosync;
    logic       wide;
    logic       run;
  } ctrl_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LO   = 2'd1;
  localparam logic [1:0] A_HI   = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
endpackage

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tmr16_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e src_i,
  input  logic osc_sel_i,
  input  logic nosync_i,
  input  logic pin_i,
  input  logic osc_i,
  output logic tick_o
);
  logic [DIV_W-1:0] div_q;
  logic raw, s1_q, s2_q, s3_q, pq_q, ext_tick;

  assign raw = osc_sel_i ? osc_i : pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      pq_q  <= 1'b0;
    end else begin
      div_q <= div_q + DIV_W'(1);
      s1_q  <= raw;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      pq_q  <= raw;
    end
  end

  assign ext_tick = nosync_i ? (raw & ~pq_q) : (s2_q & ~s3_q);

  always_comb begin
    unique case (src_i)
      SRC_DIV4: tick_o = &div_q;
      SRC_SYS:  tick_o = 1'b1;
      SRC_EXT:  tick_o = ext_tick;
      default:  tick_o = 1'b0;
    endcase
  end

  // synchronised edge must come from input seen two clocks earlier
  assert_sync_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_EXT && !nosync_i && tick_o) |-> $past(raw, 2));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            clr_i,
  output logic            inc_o
);
  localparam int PC_W = (1 << PS_W) - 1;

  logic [PC_W-1:0] pcnt_q, limit;
  logic [PC_W:0]   lim_full;

  assign lim_full = ((PC_W+1)'(1) << ps_i) - (PC_W+1)'(1);
  assign limit    = lim_full[PC_W-1:0];
  assign inc_o    = tick_i && (pcnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcnt_q <= '0;
    else if (clr_i)  pcnt_q <= '0;
    else if (tick_i) pcnt_q <= inc_o ? '0 : pcnt_q + PC_W'(1);
  end

  assert_pcnt_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= limit);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          wide_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic          rd_lo_i,
  input  logic          flag_clr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [2*DW-1:0] cnt_o,
  output logic [DW-1:0] hi_rbuf_o,
  output logic          flag_o
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] hi_wbuf_q, hi_rbuf_q;
  logic          flag_q, cnt_wr, wrap;

  assign cnt_wr = wr_lo_i | (wr_hi_i & ~wide_i);
  assign wrap   = inc_i && (cnt_q == {CW{1'b1}}) && !cnt_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      hi_wbuf_q <= '0;
      hi_rbuf_q <= '0;
      flag_q    <= 1'b0;
    end else begin
      if (wr_lo_i) begin
        cnt_q[DW-1:0] <= wdata_i;
        if (wide_i) cnt_q[CW-1:DW] <= hi_wbuf_q;
      end else if (wr_hi_i && !wide_i) begin
        cnt_q[CW-1:DW] <= wdata_i;
      end else if (inc_i) begin
        cnt_q <= cnt_q + CW'(1);
      end
      if (wr_hi_i && wide_i) hi_wbuf_q <= wdata_i;
      if (rd_lo_i && wide_i) hi_rbuf_q <= cnt_q[CW-1:DW];
      if (wrap)            flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign hi_rbuf_o = hi_rbuf_q;
  assign flag_o    = flag_q;

  assert_wrap_sets_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q == {CW{1'b1}} && !cnt_wr) |=> (flag_q && cnt_q == '0));
  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr_i) |=> flag_q);
  assert_wide_commit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_i && wr_lo_i) |=> (cnt_q[CW-1:DW] == $past(hi_wbuf_q)));
endmodule

// File: rtl/periph_timer16.sv
module periph_timer16
  import tmr16_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 2,
  parameter int PS_W  = 2,
  parameter int DIV_W = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o,
  input  logic          pin_i,
  input  logic          osc_i,
  output logic          ovf_o
);
  localparam int CW = 2 * DW;

  ctrl_t         ctrl_q, ctrl_d;
  logic          src_tick, run_tick, inc, ps_clr;
  logic          wr_ctrl, wr_lo, wr_hi, wr_stat, rd_lo, flag;
  logic [CW-1:0] cnt;
  logic [DW-1:0] hi_rbuf;

  assign ctrl_d  = ctrl_t'(wdata_i[7:0]);
  assign wr_ctrl = we_i && addr_i == AW'(A_CTRL);
  assign wr_lo   = we_i && addr_i == AW'(A_LO);
  assign wr_hi   = we_i && addr_i == AW'(A_HI);
  assign wr_stat = we_i && addr_i == AW'(A_STAT);
  assign rd_lo   = re_i && addr_i == AW'(A_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  assign ps_clr = wr_lo | wr_hi |
                  (wr_ctrl && (ctrl_d.ps != ctrl_q.ps || !ctrl_d.run));

  tmr_clk_sel #(.DIV_W(DIV_W)) u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (ctrl_q.src),
    .osc_sel_i (ctrl_q.osc_sel),
    .nosync_i  (ctrl_q.nosync),
    .pin_i     (pin_i),
    .osc_i     (osc_i),
    .tick_o    (src_tick)
  );

  assign run_tick = src_tick & ctrl_q.run;

  tmr_prescaler #(.PS_W(PS_W)) u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (run_tick),
    .ps_i   (ctrl_q.ps),
    .clr_i  (ps_clr),
    .inc_o  (inc)
  );

  tmr_count #(.DW(DW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (inc),
    .wide_i     (ctrl_q.wide),
    .wr_lo_i    (wr_lo),
    .wr_hi_i    (wr_hi),
    .rd_lo_i    (rd_lo),
    .flag_clr_i (wr_stat && !wdata_i[0]),
    .wdata_i    (wdata_i),
    .cnt_o      (cnt),
    .hi_rbuf_o  (hi_rbuf),
    .flag_o     (flag)
  );

  always_comb begin
    unique case (addr_i)
      AW'(A_CTRL): rdata_o = DW'(ctrl_q);
      AW'(A_LO):   rdata_o = cnt[DW-1:0];
      AW'(A_HI):   rdata_o = ctrl_q.wide ? hi_rbuf : cnt[CW-1:DW];
      default:     rdata_o = {{(DW-1){1'b0}}, flag};
    endcase
  end

  assign ovf_o = flag;

  assert_halt_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !we_i) |=> $stable(cnt));
endmodule

// File: tb/tb_periph_timer16.sv
module tb_periph_timer16;
  localparam int CLK_P = 10;

  logic clk_i = 0, rst_ni = 0;
  logic [1:0] addr_i = 0;
  logic [7:0] wdata_i = 0;
  logic we_i = 0, re_i = 0, pin_i = 0, osc_i = 0;
  logic [7:0] rdata_o;
  logic ovf_o;

  int checks = 0, errors = 0;

  periph_timer16 dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  // reference model
  int m_div, m_pc;
  bit m_s1, m_s2, m_s3, m_pq, m_flag;
  bit [7:0] m_ctrl, m_hib, m_hwb;
  bit [15:0] m_cnt;

  function automatic bit [7:0] exp_rd(input bit [1:0] a);
    case (a)
      0: return m_ctrl;
      1: return m_cnt[7:0];
      2: return m_ctrl[1] ? m_hib : m_cnt[15:8];
      default: return {7'b0, m_flag};
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_div = 0; m_pc = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pq = 0;
      m_flag = 0; m_ctrl = 0; m_hib = 0; m_hwb = 0; m_cnt = 0;
    end else begin
      automatic bit raw = m_ctrl[3] ? osc_i : pin_i;
      automatic bit tk;
      automatic bit inc, cwr, clr;
      automatic bit [15:0] old = m_cnt;
      case (m_ctrl[7:6])
        0: tk = (m_div == 3);
        1: tk = 1;
        2: tk = m_ctrl[2] ? (raw && !m_pq) : (m_s2 && !m_s3);
        default: tk = 0;
      endcase
      tk  = tk && m_ctrl[0];
      inc = tk && (m_pc == (1 << m_ctrl[5:4]) - 1);
      cwr = we_i && (addr_i == 1 || (addr_i == 2 && !m_ctrl[1]));
      clr = we_i && (addr_i == 1 || addr_i == 2 ||
            (addr_i == 0 && (wdata_i[5:4] != m_ctrl[5:4] || !wdata_i[0])));
      if (inc && old == 16'hFFFF && !cwr) m_flag = 1;
      else if (we_i && addr_i == 3 && !wdata_i[0]) m_flag = 0;
      if (we_i && addr_i == 1) m_cnt = {m_ctrl[1] ? m_hwb : old[15:8], wdata_i};
      else if (we_i && addr_i == 2 && !m_ctrl[1]) m_cnt[15:8] = wdata_i;
      else if (inc) m_cnt = old + 1;
      if (we_i && addr_i == 2 && m_ctrl[1]) m_hwb = wdata_i;
      if (re_i && addr_i == 1 && m_ctrl[1]) m_hib = old[15:8];
      if (clr) m_pc = 0;
      else if (tk) m_pc = inc ? 0 : m_pc + 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = raw; m_pq = raw;
      m_div = (m_div + 1) % 4;
      if (we_i && addr_i == 0) m_ctrl = wdata_i;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // flag compared every cycle
  always @(negedge clk_i) if (rst_ni) chk("R7 ovf_o", ovf_o, m_flag);

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1;
    @(negedge clk_i); we_i = 0;
  endtask

  task automatic rd(input bit [1:0] a, input string req);
    addr_i = a; re_i = 1; #1;
    chk(req, rdata_o, exp_rd(a));
    @(negedge clk_i); re_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic clear_cnt;
    wr(0, 8'h00); wr(1, 0); wr(2, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit [7:0] save;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      addr_i = a[1:0]; #1; chk("R1 reset reg", rdata_o, 0); @(negedge clk_i);
    end
    chk("R1 ovf_o reset", ovf_o, 0);

    // R2 system clock, running reads
    wr(0, 8'h41);
    for (int i = 0; i < 6; i++) begin rd(1, "R2 sys lo"); idle(i); end
    wr(0, 8'h40); rd(1, "R2 sys halted lo"); rd(2, "R2 sys hi");
    // R2 divide-by-4 source
    clear_cnt(); wr(0, 8'h01); idle(37); rd(1, "R2 div4 lo");
    wr(0, 8'h00); rd(1, "R2 div4 halted");

    // R3 prescales
    for (int p = 1; p < 4; p++) begin
      clear_cnt(); wr(0, 8'h41 | (p << 4)); idle(45 + p);
      rd(1, "R3 prescale running"); wr(0, 8'h40 | (p << 4));
      rd(1, "R3 prescale lo");
    end

    // R4 external pin, synchronised then not
    foreach (save[i]) begin end
    for (int m = 0; m < 3; m++) begin
      clear_cnt();
      wr(0, m == 0 ? 8'h81 : (m == 1 ? 8'h85 : 8'h89));
      for (int k = 0; k < 9; k++) begin
        pin_i = ~pin_i; idle(1 + (k % 3));
        if (m == 2 && k % 2 == 0) osc_i = ~osc_i;
        rd(1, "R4 ext count");
      end
      wr(0, 8'h00); idle(2); rd(1, "R4 ext final");
    end
    pin_i = 0; osc_i = 0;
    // R4 bits 3,2 ignored with internal source
    clear_cnt(); wr(0, 8'h4D); idle(10); wr(0, 8'h4C); rd(1, "R4 internal ignores bits");

    // R5 reserved source
    clear_cnt(); wr(0, 8'hC1);
    for (int k = 0; k < 8; k++) begin pin_i = ~pin_i; osc_i = ~osc_i; idle(1); end
    addr_i = 1; #1; chk("R5 reserved no count", rdata_o, 0); @(negedge clk_i);

    // R6 halt holds count and drops prescale residue
    wr(0, 8'h71); idle(13); wr(0, 8'h70);
    addr_i = 1; #1; save = rdata_o; idle(10); #1;
    chk("R6 halted hold", rdata_o, save); @(negedge clk_i);
    wr(0, 8'h71); idle(5); wr(0, 8'h70); rd(1, "R6 residue discarded");

    // R7 overflow, sticky, write 1 ignored
    wr(0, 8'h40); wr(1, 8'hFD); wr(2, 8'hFF); wr(0, 8'h41); idle(6);
    #1; chk("R7 flag set after wrap", ovf_o, 1); @(negedge clk_i);
    wr(3, 8'h01); rd(3, "R7 write one ignored");
    wr(0, 8'h40); wr(3, 8'h00); rd(3, "R7 cleared");
    // set wins over same-cycle clear
    wr(1, 8'hFA); wr(2, 8'hFF); wr(0, 8'h41);
    for (int k = 0; k < 10; k++) wr(3, 8'h00);
    wr(0, 8'h40); rd(3, "R7 set priority");
    wr(3, 8'h00);

    // R8 byte-wise access
    wr(1, 8'h34); wr(2, 8'h12); rd(1, "R8 lo"); rd(2, "R8 hi");
    addr_i = 2; #1; chk("R8 hi direct", rdata_o, 8'h12); @(negedge clk_i);

    // R9 wide mode write buffer and read snapshot
    wr(0, 8'h42); wr(2, 8'hAB);
    addr_i = 2; #1; chk("R9 hi not yet committed", rdata_o, exp_rd(2)); @(negedge clk_i);
    wr(1, 8'hCD); wr(0, 8'h40);
    addr_i = 2; #1; chk("R9 hi committed", rdata_o, 8'hAB); @(negedge clk_i);
    addr_i = 1; #1; chk("R9 lo committed", rdata_o, 8'hCD); @(negedge clk_i);
    wr(1, 8'hF0); wr(0, 8'h43);
    rd(1, "R9 snapshot lo"); idle(40); rd(2, "R9 snapshot hi"); idle(20);
    rd(1, "R9 snapshot lo2"); rd(2, "R9 snapshot hi2");

    // R10 prescale change and count write mid-period, R11 write beats increment
    clear_cnt(); wr(0, 8'h71); idle(5); wr(0, 8'h61); idle(3); wr(0, 8'h71);
    idle(4); wr(1, 8'h10); idle(6); rd(1, "R10 restart");
    wr(0, 8'h41); wr(1, 8'h80); rd(1, "R11 write wins"); wr(2, 8'h55);
    rd(2, "R11 hi write wins"); rd(1, "R11 lo after");
    wr(0, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule